// File: doc/BRIEF.md
# ATA PIO register access engine

This block sits on the host side of up to four parallel ATA buses. It runs single task-file register cycles on them. A CPU writes one command word through a small register port. The word selects the bus, the task-file register address, the two chip selects and the direction, and it carries 16 bits of write data. The engine then runs one PIO cycle on the chosen bus: a setup phase, a strobe phase and a hold phase. Each phase lasts a programmed number of controller clocks. The chip selects and the address stay valid through all three phases.

On a read cycle the word on the ATA data pins is captured on the clock edge where the read strobe deasserts. Software then sees it in the low half of the status register, together with a data-valid flag. Reading the status register clears that flag and a sticky overrun flag. The overrun flag records a command that arrived while a cycle was still running; such a command is dropped.

Each bus has its own interrupt request input. A rising edge on it makes that bus pending. A per-bus mask decides which pending bus drives the combined interrupt output, and a one-hot write clears pending bits. A control register holds the global enable and the drive reset output.

Top module: `ata_pio_engine`

Register offsets on `reg_addr`:
- 0: command
- 1: status
- 2: timing
- 3: control
- 4: interrupt mask
- 5: pending read / acknowledge write

## Requirements
- R1: After reset the interface is idle. All strobes and chip selects are high, `ata_rst_n` is high and `irq` is low. Timing (offset 2) reads 0x010703, which is hold in bits 21:16, strobe in bits 13:8 and setup in bits 5:0. Status (offset 1) reads 0x020000. Control reads 0.
- R2: An accepted command starts a cycle. It has max(setup,1) clocks of setup, then max(strobe,1) clocks of strobe, then max(hold,1) clocks of hold. Status bit 16 (busy) is 1 for the whole cycle. Status bit 17 (ready) is 0 during setup and strobe and 1 otherwise. `ata_addr` is 0 when idle.
- R3: `ata_dior_n` (read) or `ata_diow_n` (write) is low only during the strobe phase. On a write, `ata_doe` is 1 and `ata_dout` carries the data for the whole cycle.
- R4: Command bits 23:22 select the bus, 21:19 the register address, bit 18 asserts CS1 and bit 17 asserts CS0. Bit 16 set means read, and bits 15:0 are the data. Only the selected bus's `ata_cs0_n`/`ata_cs1_n` go low, and only the bits that are set. Address 6 with only CS1 reaches the device control register.
- R5: On a read, the value on `ata_din` at the edge that ends the strobe appears in status bits 15:0, and status bit 18 (data valid) is set.
- R6: A status read clears data valid and status bit 19 (overrun).
- R7: A command written while busy is ignored. The running cycle is unchanged and overrun is set.
- R8: A command written while control bit 0 (enable) is 0 starts no cycle.
- R9: Timing values are taken when a cycle starts. A timing write during a cycle only affects later cycles.
- R10: A rising edge on `ata_intrq[b]` sets pending bit b (offset 5). `irq_vec` is pending AND mask, and `irq` is the OR of `irq_vec`.
- R11: Writing offset 5 clears every pending bit whose data bit is 1 and leaves the others. An input held high does not pend again.
- R12: Control bit 1 drives `ata_rst_n` low while set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | controller clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (side effects on status) |
| reg_addr | input | 3 | register offset |
| reg_wdata | input | 24 | register write data |
| reg_rdata | output | 24 | register read data, combinational on reg_addr |
| ata_rst_n | output | 1 | drive reset, active low |
| ata_addr | output | 3 | task-file address |
| ata_cs0_n | output | 4 | per-bus CS0, active low |
| ata_cs1_n | output | 4 | per-bus CS1, active low |
| ata_dior_n | output | 1 | read strobe, active low |
| ata_diow_n | output | 1 | write strobe, active low |
| ata_dout | output | 16 | write data |
| ata_doe | output | 1 | write data output enable |
| ata_din | input | 16 | read data from the bus |
| ata_intrq | input | 4 | per-bus interrupt request |
| irq_vec | output | 4 | masked pending interrupts |
| irq | output | 1 | combined interrupt |

## Verification
The bench sweeps setup, strobe and hold counts from 0 up to the slowest mode (9, 39, 9). A design that treated 0 as zero cycles, or was off by one in any phase, shifts every later pin edge and fails the pin trace. Read data changes on the last strobe clock, so a design that samples one edge early returns the older word. A second command sent during a cycle, and a timing write sent during a cycle, show whether the running cycle was disturbed. That happens if the address or strobe length changes, or if overrun stays clear. Masked interrupts, a held-high request after an acknowledge, and a one-hot acknowledge that must leave other buses pending expose level-triggered or all-clearing designs.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;

  localparam logic [2:0] OFS_CMD  = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_TIME = 3'd2;
  localparam logic [2:0] OFS_CTRL = 3'd3;
  localparam logic [2:0] OFS_MASK = 3'd4;
  localparam logic [2:0] OFS_IRQ  = 3'd5;

  localparam int TIME_SETUP_LSB  = 0;
  localparam int TIME_STROBE_LSB = 8;
  localparam int TIME_HOLD_LSB   = 16;

endpackage

// File: rtl/ata_pio_timing.sv
module ata_pio_timing
  import ata_pio_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] setup_cnt,
  input  logic [CNT_W-1:0] strobe_cnt,
  input  logic [CNT_W-1:0] hold_cnt,
  output phase_t           phase,
  output logic             busy,
  output logic             tr_rdy,
  output logic             strobe_end
);

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] strb_q, strb_d;
  logic [CNT_W-1:0] hld_q, hld_d;

  function automatic logic [CNT_W-1:0] first_load(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - CNT_W'(1);
  endfunction

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    strb_d  = strb_q;
    hld_d   = hld_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = first_load(setup_cnt);
          strb_d  = strobe_cnt;
          hld_d   = hold_cnt;
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          phase_d = PH_STROBE;
          cnt_d   = first_load(strb_q);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_STROBE: begin
        if (cnt_q == '0) begin
          phase_d = PH_HOLD;
          cnt_d   = first_load(hld_q);
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_HOLD: begin
        if (cnt_q == '0) phase_d = PH_IDLE;
        else             cnt_d   = cnt_q - CNT_W'(1);
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      strb_q  <= '0;
      hld_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      strb_q  <= strb_d;
      hld_q   <= hld_d;
    end
  end

  assign phase      = phase_q;
  assign busy       = (phase_q != PH_IDLE);
  assign tr_rdy     = (phase_q == PH_IDLE) || (phase_q == PH_HOLD);
  assign strobe_end = (phase_q == PH_STROBE) && (cnt_q == '0);

endmodule

// File: rtl/ata_pio_irq.sv
module ata_pio_irq #(
  parameter int NUM_BUS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_BUS-1:0] intrq,
  input  logic [NUM_BUS-1:0] mask,
  input  logic [NUM_BUS-1:0] ack,
  output logic [NUM_BUS-1:0] pending,
  output logic [NUM_BUS-1:0] irq_vec,
  output logic               irq
);

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic sync1_q, sync2_q, last_q, pend_q, pend_d, rise;

    assign rise   = sync2_q && !last_q;
    assign pend_d = rise || (pend_q && !ack[b]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync1_q <= 1'b0;
        sync2_q <= 1'b0;
        last_q  <= 1'b0;
        pend_q  <= 1'b0;
      end else begin
        sync1_q <= intrq[b];
        sync2_q <= sync1_q;
        last_q  <= sync2_q;
        pend_q  <= pend_d;
      end
    end

    assign pending[b] = pend_q;
  end

  assign irq_vec = pending & mask;
  assign irq     = |irq_vec;

endmodule

// File: rtl/ata_pio_regs.sv
module ata_pio_regs
  import ata_pio_pkg::*;
#(
  parameter int NUM_BUS    = 4,
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 6,
  parameter int CMD_W      = 24,
  parameter int DEF_SETUP  = 3,
  parameter int DEF_STROBE = 7,
  parameter int DEF_HOLD   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [CMD_W-1:0]   reg_wdata,
  output logic [CMD_W-1:0]   reg_rdata,
  input  logic               busy,
  input  logic               tr_rdy,
  input  logic               rd_capture,
  input  logic [DATA_W-1:0]  cap_data,
  input  logic [NUM_BUS-1:0] pending,
  output logic               cmd_start,
  output logic [CMD_W-1:0]   cmd_word,
  output logic [CNT_W-1:0]   t_setup,
  output logic [CNT_W-1:0]   t_strobe,
  output logic [CNT_W-1:0]   t_hold,
  output logic               enable,
  output logic               rst_assert,
  output logic [NUM_BUS-1:0] irq_mask,
  output logic [NUM_BUS-1:0] ack_vec,
  output logic               dav,
  output logic               overrun
);

  logic [CMD_W-1:0]   cmd_q;
  logic [CNT_W-1:0]   setup_q, strobe_q, hold_q;
  logic               en_q, rsta_q;
  logic [NUM_BUS-1:0] mask_q;
  logic [DATA_W-1:0]  rdat_q;
  logic               dav_q, dav_d, ovr_q, ovr_d;

  logic wr_cmd, wr_time, wr_ctrl, wr_mask, wr_irq, rd_stat, ovr_evt;

  assign wr_cmd    = reg_wr && (reg_addr == OFS_CMD);
  assign wr_time   = reg_wr && (reg_addr == OFS_TIME);
  assign wr_ctrl   = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_mask   = reg_wr && (reg_addr == OFS_MASK);
  assign wr_irq    = reg_wr && (reg_addr == OFS_IRQ);
  assign rd_stat   = reg_rd && (reg_addr == OFS_STAT);
  assign cmd_start = wr_cmd && en_q && !busy;
  assign ovr_evt   = wr_cmd && busy;

  always_comb begin
    dav_d = dav_q;
    if (rd_capture)   dav_d = 1'b1;
    else if (rd_stat) dav_d = 1'b0;
    ovr_d = ovr_q;
    if (ovr_evt)      ovr_d = 1'b1;
    else if (rd_stat) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      setup_q  <= CNT_W'(DEF_SETUP);
      strobe_q <= CNT_W'(DEF_STROBE);
      hold_q   <= CNT_W'(DEF_HOLD);
      en_q     <= 1'b0;
      rsta_q   <= 1'b0;
      mask_q   <= '0;
      rdat_q   <= '0;
      dav_q    <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (cmd_start) cmd_q <= reg_wdata;
      if (wr_time) begin
        setup_q  <= reg_wdata[TIME_SETUP_LSB  +: CNT_W];
        strobe_q <= reg_wdata[TIME_STROBE_LSB +: CNT_W];
        hold_q   <= reg_wdata[TIME_HOLD_LSB   +: CNT_W];
      end
      if (wr_ctrl) begin
        en_q   <= reg_wdata[0];
        rsta_q <= reg_wdata[1];
      end
      if (wr_mask)    mask_q <= reg_wdata[NUM_BUS-1:0];
      if (rd_capture) rdat_q <= cap_data;
      dav_q <= dav_d;
      ovr_q <= ovr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_CMD:  reg_rdata = cmd_q;
      OFS_STAT: begin
        reg_rdata[DATA_W-1:0] = rdat_q;
        reg_rdata[DATA_W]     = busy;
        reg_rdata[DATA_W+1]   = tr_rdy;
        reg_rdata[DATA_W+2]   = dav_q;
        reg_rdata[DATA_W+3]   = ovr_q;
      end
      OFS_TIME: begin
        reg_rdata[TIME_SETUP_LSB  +: CNT_W] = setup_q;
        reg_rdata[TIME_STROBE_LSB +: CNT_W] = strobe_q;
        reg_rdata[TIME_HOLD_LSB   +: CNT_W] = hold_q;
      end
      OFS_CTRL: reg_rdata[1:0] = {rsta_q, en_q};
      OFS_MASK: reg_rdata[NUM_BUS-1:0] = mask_q;
      OFS_IRQ:  reg_rdata[NUM_BUS-1:0] = pending;
      default:  reg_rdata = '0;
    endcase
  end

  assign cmd_word   = cmd_q;
  assign t_setup    = setup_q;
  assign t_strobe   = strobe_q;
  assign t_hold     = hold_q;
  assign enable     = en_q;
  assign rst_assert = rsta_q;
  assign irq_mask   = mask_q;
  assign ack_vec    = wr_irq ? reg_wdata[NUM_BUS-1:0] : '0;
  assign dav        = dav_q;
  assign overrun    = ovr_q;

endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter  int NUM_BUS    = 4,
  parameter  int DATA_W     = 16,
  parameter  int CNT_W      = 6,
  parameter  int DEF_SETUP  = 3,
  parameter  int DEF_STROBE = 7,
  parameter  int DEF_HOLD   = 1,
  localparam int BUS_W      = $clog2(NUM_BUS),
  localparam int CMD_W      = DATA_W + 6 + BUS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [2:0]         reg_addr,
  input  logic [CMD_W-1:0]   reg_wdata,
  output logic [CMD_W-1:0]   reg_rdata,
  output logic               ata_rst_n,
  output logic [2:0]         ata_addr,
  output logic [NUM_BUS-1:0] ata_cs0_n,
  output logic [NUM_BUS-1:0] ata_cs1_n,
  output logic               ata_dior_n,
  output logic               ata_diow_n,
  output logic [DATA_W-1:0]  ata_dout,
  output logic               ata_doe,
  input  logic [DATA_W-1:0]  ata_din,
  input  logic [NUM_BUS-1:0] ata_intrq,
  output logic [NUM_BUS-1:0] irq_vec,
  output logic               irq
);

  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  phase_t             phase;
  logic               busy, tr_rdy, strobe_end, rd_capture, cmd_start;
  logic [CMD_W-1:0]   cmd_word;
  logic [CNT_W-1:0]   t_setup, t_strobe, t_hold;
  logic               enable, rst_assert, dav, overrun;
  logic [NUM_BUS-1:0] irq_mask, ack_vec, pending;

  logic [BUS_W-1:0]  cmd_bus;
  logic [2:0]        cmd_addr;
  logic              cmd_cs0, cmd_cs1, cmd_rd;
  logic [DATA_W-1:0] cmd_data;

  assign cmd_data = cmd_word[DATA_W-1:0];
  assign cmd_rd   = cmd_word[DATA_W];
  assign cmd_cs0  = cmd_word[DATA_W+1];
  assign cmd_cs1  = cmd_word[DATA_W+2];
  assign cmd_addr = cmd_word[DATA_W+3 +: 3];
  assign cmd_bus  = cmd_word[DATA_W+6 +: BUS_W];

  ata_pio_regs #(
    .NUM_BUS(NUM_BUS), .DATA_W(DATA_W), .CNT_W(CNT_W), .CMD_W(CMD_W),
    .DEF_SETUP(DEF_SETUP), .DEF_STROBE(DEF_STROBE), .DEF_HOLD(DEF_HOLD)
  ) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .busy(busy), .tr_rdy(tr_rdy), .rd_capture(rd_capture), .cap_data(ata_din),
    .pending(pending), .cmd_start(cmd_start), .cmd_word(cmd_word),
    .t_setup(t_setup), .t_strobe(t_strobe), .t_hold(t_hold),
    .enable(enable), .rst_assert(rst_assert), .irq_mask(irq_mask),
    .ack_vec(ack_vec), .dav(dav), .overrun(overrun)
  );

  ata_pio_timing #(.CNT_W(CNT_W)) u_timing (
    .clk(clk), .rst_n(rst_sync_n), .start(cmd_start),
    .setup_cnt(t_setup), .strobe_cnt(t_strobe), .hold_cnt(t_hold),
    .phase(phase), .busy(busy), .tr_rdy(tr_rdy), .strobe_end(strobe_end)
  );

  ata_pio_irq #(.NUM_BUS(NUM_BUS)) u_irq (
    .clk(clk), .rst_n(rst_sync_n), .intrq(ata_intrq), .mask(irq_mask),
    .ack(ack_vec), .pending(pending), .irq_vec(irq_vec), .irq(irq)
  );

  assign rd_capture = strobe_end && cmd_rd;

  for (genvar b = 0; b < NUM_BUS; b++) begin : g_cs
    logic sel;
    assign sel          = busy && (cmd_bus == BUS_W'(b));
    assign ata_cs0_n[b] = !(sel && cmd_cs0);
    assign ata_cs1_n[b] = !(sel && cmd_cs1);
  end

  assign ata_addr   = busy ? cmd_addr : 3'd0;
  assign ata_dior_n = !((phase == PH_STROBE) && cmd_rd);
  assign ata_diow_n = !((phase == PH_STROBE) && !cmd_rd);
  assign ata_dout   = cmd_data;
  assign ata_doe    = busy && !cmd_rd;
  assign ata_rst_n  = !rst_assert;

endmodule

// File: rtl/ata_pio_checker.sv
module ata_pio_checker #(
  parameter int NUM_BUS = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [2:0]         reg_addr,
  input logic               busy,
  input logic               rd_capture,
  input logic               dav,
  input logic               overrun,
  input logic               enable,
  input logic               ata_dior_n,
  input logic               ata_diow_n,
  input logic [NUM_BUS-1:0] ata_cs0_n,
  input logic [NUM_BUS-1:0] ata_cs1_n,
  input logic [2:0]         ata_addr
);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ata_dior_n && ata_diow_n && (&ata_cs0_n) && (&ata_cs1_n)));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));

  p_strobe_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ata_dior_n || !ata_diow_n) |-> busy);

  p_cs_one_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~(ata_cs0_n & ata_cs1_n)));

  p_dav_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> dav);

  p_dav_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd1 && !rd_capture) |=> !dav);

  p_overrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && busy) |=> overrun);

  p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd0 && !enable && !busy) |=> !busy);

  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ata_addr));

endmodule

bind ata_pio_engine ata_pio_checker #(.NUM_BUS(NUM_BUS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .busy(busy), .rd_capture(rd_capture), .dav(dav),
  .overrun(overrun), .enable(enable), .ata_dior_n(ata_dior_n),
  .ata_diow_n(ata_diow_n), .ata_cs0_n(ata_cs0_n), .ata_cs1_n(ata_cs1_n),
  .ata_addr(ata_addr)
);

// File: tb/tb_ata_pio_engine.sv
module tb_ata_pio_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [23:0] reg_wdata, reg_rdata;
  logic        ata_rst_n, ata_dior_n, ata_diow_n, ata_doe, irq;
  logic [2:0]  ata_addr;
  logic [3:0]  ata_cs0_n, ata_cs1_n, ata_intrq, irq_vec;
  logic [15:0] ata_dout, ata_din;

  always #4 clk = ~clk;

  ata_pio_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ata_rst_n(ata_rst_n), .ata_addr(ata_addr), .ata_cs0_n(ata_cs0_n),
    .ata_cs1_n(ata_cs1_n), .ata_dior_n(ata_dior_n), .ata_diow_n(ata_diow_n),
    .ata_dout(ata_dout), .ata_doe(ata_doe), .ata_din(ata_din),
    .ata_intrq(ata_intrq), .irq_vec(irq_vec), .irq(irq)
  );

  int nchk = 0;
  int nfail = 0;
  logic [15:0] last_cap = 16'h0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [23:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 3'd1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [23:0] v);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 3'd1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [23:0] cmdw(input int bus, input int a, input bit c0,
                                       input bit c1, input bit r, input int data);
    return {bus[1:0], a[2:0], c1, c0, r, data[15:0]};
  endfunction

  function automatic logic [23:0] timw(input int s, input int t, input int h);
    return {2'b0, h[5:0], 2'b0, t[5:0], 2'b0, s[5:0]};
  endfunction

  // R2 R3 R4 R5: full cycle trace against expected phase timing
  task automatic run_cycle(input int bus, input int a, input bit c0, input bit c1,
                           input bit r, input int data, input int s, input int t,
                           input int h, input int din_a, input int din_b,
                           input string tag);
    int se, te, he, bad, fn;
    logic [31:0] ex, ac, fa, fe;
    logic [23:0] st;
    logic [3:0]  selm;
    se = (s == 0) ? 1 : s; te = (t == 0) ? 1 : t; he = (h == 0) ? 1 : h;
    bad = 0; fn = 0; fa = '0; fe = '0;
    selm = 4'b0001 << bus;
    wr(3'd2, timw(s, t, h));
    wr(3'd0, cmdw(bus, a, c0, c1, r, data));
    for (int n = 1; n <= se + te + he + 1; n++) begin
      bit inb, instr, inhold;
      if (n == se + 1)  ata_din = din_a[15:0];
      if (n == se + te) ata_din = din_b[15:0];
      #1;
      inb    = (n <= se + te + he);
      instr  = (n > se) && (n <= se + te);
      inhold = (n > se + te) && inb;
      ex[15]    = !(instr && r);
      ex[14]    = !(instr && !r);
      ex[13:10] = ~((inb && c0) ? selm : 4'b0);
      ex[9:6]   = ~((inb && c1) ? selm : 4'b0);
      ex[5:3]   = inb ? a[2:0] : 3'd0;
      ex[2]     = inb && !r;
      ex[1]     = inb;
      ex[0]     = !inb || inhold;
      ex[31:16] = (inb && !r) ? data[15:0] : 16'h0;
      ac[15:0]  = {ata_dior_n, ata_diow_n, ata_cs0_n, ata_cs1_n, ata_addr,
                   ata_doe, reg_rdata[16], reg_rdata[17]};
      ac[31:16] = ata_doe ? ata_dout : 16'h0;
      if (ac !== ex) begin
        if (bad == 0) begin fn = n; fa = ac; fe = ex; end
        bad++;
      end
      @(negedge clk);
    end
    nchk++;
    if (bad != 0) begin
      nfail++;
      $display("FAIL R2/R3/R4 %s trace at cycle %0d actual=%h expected=%h", tag, fn, fa, fe);
    end
    if (r) last_cap = din_b[15:0];
    rd(3'd1, st);
    check({"R5 status after ", tag}, {8'h0, st},
          {8'h0, 1'b0, r, 1'b1, 1'b0, last_cap});
  endtask

  logic [23:0] v;
  int sd;

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 3'd1; reg_wdata = '0;
    ata_din = 16'h0; ata_intrq = 4'h0;
    sd = $urandom(32'h00C0FFEE);
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    #1;
    check("R1 pins idle", {ata_dior_n, ata_diow_n, ata_cs0_n, ata_cs1_n, ata_rst_n, irq},
          {1'b1, 1'b1, 4'hF, 4'hF, 1'b1, 1'b0});
    rd(3'd2, v); check("R1 timing default", {8'h0, v}, 32'h010703);
    rd(3'd1, v); check("R1 status", {8'h0, v}, 32'h020000);
    rd(3'd3, v); check("R1 control", {8'h0, v}, 32'h0);

    // R8 disabled engine ignores command
    wr(3'd0, cmdw(0, 1, 1, 0, 0, 16'h1234));
    #1 check("R8 no cycle when disabled", {reg_rdata[16], ata_cs0_n, ata_diow_n}, {1'b0, 4'hF, 1'b1});
    idle(1);

    wr(3'd3, 24'h1);
    // R2 defaults after enable (timing rewritten with same defaults inside run_cycle)
    run_cycle(2, 3, 1, 0, 0, 16'hA55A, 3, 7, 1, 0, 0, "default write");
    // R5 slowest mode with late data change
    run_cycle(1, 0, 1, 0, 1, 0, 9, 39, 9, 16'h1111, 16'hBEEF, "slowest read");
    // R4 device control register
    run_cycle(1, 6, 0, 1, 0, 16'h0004, 3, 9, 3, 0, 0, "device control");
    // R2 zero counts act as one
    run_cycle(3, 7, 1, 0, 1, 0, 0, 0, 0, 16'h7777, 16'h2468, "zero counts");

    // R6 status read clears data valid
    run_cycle(0, 2, 1, 0, 1, 0, 2, 3, 2, 16'h5555, 16'h4321, "dav pre");
    rd(3'd1, v); check("R6 dav cleared by status read", {31'h0, v[18]}, 32'h0);

    // R7 overrun
    wr(3'd2, timw(4, 4, 4));
    wr(3'd0, cmdw(0, 2, 1, 0, 0, 16'h0F0F));
    wr(3'd0, cmdw(3, 5, 0, 1, 1, 16'h0));
    #1 check("R7 running cycle kept", {ata_addr, ata_cs0_n, ata_cs1_n}, {3'd2, 4'hE, 4'hF});
    idle(14);
    #1 check("R7 second command dropped", {31'h0, reg_rdata[16]}, 32'h0);
    rd(3'd1, v); check("R7 overrun set", {31'h0, v[19]}, 32'h1);
    rd(3'd1, v); check("R6 overrun cleared by status read", {31'h0, v[19]}, 32'h0);

    // R9 timing snapshot
    begin
      int low;
      low = 0;
      wr(3'd2, timw(2, 5, 2));
      wr(3'd0, cmdw(1, 4, 1, 0, 1, 16'h0));
      wr(3'd2, timw(2, 20, 2));
      for (int i = 0; i < 40; i++) begin
        #1 if (!ata_dior_n) low++;
        @(negedge clk);
      end
      check("R9 strobe length from start-time value", low, 5);
      rd(3'd1, v);
      last_cap = ata_din;
    end

    // R10 / R11 interrupts
    wr(3'd4, 24'h5);
    ata_intrq = 4'b0001; idle(4);
    #1 check("R10 masked-in pending drives irq", {irq_vec, irq}, {4'b0001, 1'b1});
    ata_intrq = 4'b0011; idle(4);
    rd(3'd5, v); check("R10 masked bus pends without irq", {v[3:0], irq_vec}, {4'b0011, 4'b0001});
    wr(3'd5, 24'h1);
    idle(3);
    rd(3'd5, v); check("R11 ack clears only bus 0", {v[3:0], irq}, {4'b0010, 1'b0});
    ata_intrq = 4'b0000; idle(4);
    ata_intrq = 4'b0100; idle(4);
    #1 check("R10 bus 2 edge", {irq_vec, irq}, {4'b0100, 1'b1});
    wr(3'd5, 24'hF); idle(1);
    rd(3'd5, v); check("R11 held input does not re-pend", {28'h0, v[3:0]}, 32'h0);
    ata_intrq = 4'b0000;

    // R12 reset control
    wr(3'd3, 24'h3);
    #1 check("R12 reset asserted", {31'h0, ata_rst_n}, 32'h0);
    wr(3'd3, 24'h1);
    #1 check("R12 reset released", {31'h0, ata_rst_n}, 32'h1);

    // constrained random cycles
    for (int k = 0; k < 40; k++) begin
      int bus, a, r, data, s, t, h, c;
      bus = $urandom_range(3); a = $urandom_range(7); r = $urandom_range(1);
      data = $urandom_range(16'hFFFF); c = $urandom_range(2);
      s = $urandom_range(10); t = $urandom_range(12); h = $urandom_range(10);
      run_cycle(bus, a, c != 1, c != 0, r[0], data, s, t, h,
                $urandom_range(16'hFFFF), $urandom_range(16'hFFFF), "random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule